// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Loopback Test Modes

This block is one full-duplex asynchronous serial channel. A byte-wide register bus loads characters into a two-entry transmit queue and takes characters out of a four-entry receive queue. A shared 16-bit divider produces an oversample tick, and every bit lasts sixteen ticks. The receiver confirms a start bit at its midpoint and samples each later bit at its centre. Character length, parity and the length of the transmitted stop bit are programmable. The stop bit can be set in sixteenths of a bit, from one bit up to two.

A clear-to-send input holds back the start of each new character, and a request-to-send output is driven from a register bit. Each received character carries its own parity-error and framing-error flags through the receive queue. An overrun flag is set when a character arrives while the queue is full. One interrupt line combines three maskable sources: receive ready, transmit ready and error.

The line can be routed four ways: normal operation, automatic echo, local loopback and remote loopback. These modes are used for bring-up and for testing the cable.

Top module: `serial_uart`

Register map (`regSel`): 0 data (a write queues a character for sending; a read shows the oldest received character, and `rdEn` removes it); 1 status (read), where writing bit 4 as 1 clears overrun; 2 frame format; 3 stop extension; 4 line mode, RTS and interrupt masks; 5 divisor low byte; 6 divisor high byte.

## Requirements
- R1: Format bits [1:0] select the character length: codes 0, 1, 2 and 3 give 5, 6, 7 and 8 data bits. A frame is one low start bit, then the data bits with the least significant bit first, then an optional parity bit, then a high stop level. The line idles high.
- R2: Format bits [3:2] select parity: 01 is even, 10 is odd, and 00 or 11 is none. The parity bit follows the last data bit. Even parity makes the total count of ones in data plus parity even, and odd parity makes it odd.
- R3: The transmitted stop level lasts 16 + min(E,16) ticks, where E is register 3 bits [4:0]. A character that is already queued starts on the tick at which the stop level ends.
- R4: The transmit queue holds two characters and the receive queue holds four. Status bit 1 (transmit space) is 0 when the transmit queue is full, and a write to a full transmit queue is discarded.
- R5: A character that completes while the receive queue holds four characters is discarded and sets status bit 4. Writing register 1 with bit 4 set clears that flag.
- R6: Each received character stores its parity-error and framing-error flags. Status bits 2 and 3 show these flags for the oldest stored character. A framing error means the stop bit was sampled low.
- R7: While `ctsIn` is low, no new character starts on `txd`. Once it goes high, queued characters are sent.
- R8: `rtsOut` takes the value of register 4 bit 2 in the cycle after that register is written.
- R9: In echo mode (register 4 bits [1:0] = 1), `txd` follows `rxd`, and the receiver still stores incoming characters.
- R10: In local loopback mode (code 2), `txd` stays high and the receiver decodes the transmitter's own output.
- R11: In remote loopback mode (code 3), `txd` follows `rxd` and the receiver stores nothing.
- R12: `irq` is the OR of three terms: receive-ready AND register 4 bit 3, transmit-space AND bit 4, and error AND bit 5. Error means overrun, or a stored character whose parity or framing flag is set.
- R13: With divisor D, a tick occurs every D+1 clocks and one bit lasts 16 ticks. Status bit 0 shows a stored character, status bit 5 shows that transmission is idle, and status bit 6 shows the level of `ctsIn`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Register address |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe; removes a received character when regSel is 0 |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the selected register |
| irq | output | 1 | Masked interrupt request |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| rtsOut | output | 1 | Request-to-send output |
| ctsIn | input | 1 | Clear-to-send input, high means transmission may proceed |

## Verification
Two transmitter functions can fall on the same tick: the end of one character's stop level and the launch of the next queued character. The bench provokes this by holding clear-to-send low while it queues two all-ones characters, then releasing it. It judges the result by counting the clocks between the two start-bit falling edges. That count must equal the frame length exactly for each stop extension, including the clamped maximum. A single extra tick of idle between the two characters would show up as a miscompare.

// File: rtl/uart_pkg.sv
package uart_pkg;
  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_ECHO   = 2'd1,
    MODE_LOCAL  = 2'd2,
    MODE_REMOTE = 2'd3
  } lineMode_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_START, PH_DATA, PH_PAR, PH_STOP
  } phase_e;

  typedef struct packed {
    logic txPush;
    logic rxPop;
    logic ovrClr;
  } strobe_t;

  typedef struct packed {
    logic [1:0] charLen;
    logic [1:0] parity;
    logic [4:0] stopExtra;
    lineMode_e  mode;
  } frameCfg_t;

  typedef struct packed {
    logic       rxAvail;
    logic       txSpace;
    logic       headPe;
    logic       headFe;
    logic       overrun;
    logic       txIdle;
    logic [7:0] rxData;
  } lineStat_t;
endpackage

// File: rtl/uart_fifo.sv
module uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         push,
  input  logic [W-1:0] pushData,
  input  logic         pop,
  output logic [W-1:0] popData,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          doPush, doPop;

  assign empty   = (count == '0);
  assign full    = (count == CW'(DEPTH));
  assign doPop   = pop && !empty;
  assign doPush  = push && (!full || doPop);
  assign popData = mem[rdPtr];

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) begin
        mem[wrPtr] <= pushData;
        wrPtr      <= bump(wrPtr);
      end
      if (doPop) rdPtr <= bump(rdPtr);
      if (doPush && !doPop) count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    count <= CW'(DEPTH));
endmodule

// File: rtl/uart_datapath.sv
module uart_datapath
  import uart_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  frameCfg_t        cfg,
  input  logic [DIV_W-1:0] divisor,
  input  logic [7:0]       wrData,
  input  logic             rxdIn,
  input  logic             ctsIn,
  output logic             txdOut,
  output lineStat_t        stat
);
  localparam int ENTRY_W = 10;

  // baud tick
  logic [DIV_W-1:0] baudCnt;
  logic             tick;
  assign tick = (baudCnt >= divisor);
  always_ff @(posedge clk) begin
    if (!rstN) baudCnt <= '0;
    else       baudCnt <= tick ? '0 : baudCnt + 1'b1;
  end

  // frame decode
  logic [2:0] lastBit;
  logic [7:0] dataMask;
  logic       parEn, parOdd;
  logic [4:0] extraClamp;
  logic [5:0] stopTicks;
  assign lastBit    = 3'd4 + 3'(cfg.charLen);
  assign dataMask   = 8'hFF >> (2'd3 - cfg.charLen);
  assign parEn      = (cfg.parity == 2'b01) || (cfg.parity == 2'b10);
  assign parOdd     = (cfg.parity == 2'b10);
  assign extraClamp = (cfg.stopExtra > 5'd16) ? 5'd16 : cfg.stopExtra;
  assign stopTicks  = 6'd16 + {1'b0, extraClamp};

  // transmit queue and engine
  logic       txEmpty, txFull;
  logic [7:0] txHead;
  logic       txLaunch;
  phase_e     txState;
  logic [5:0] txCnt;
  logic [2:0] txBit;
  logic [7:0] txShr;
  logic       txParBit, txLine;

  assign txLaunch = tick && !txEmpty && ctsIn &&
                    ((txState == PH_IDLE) ||
                     (txState == PH_STOP && txCnt == stopTicks - 6'd1));

  uart_fifo #(.W(8), .DEPTH(TX_DEPTH)) txQueue (
    .clk(clk), .rstN(rstN), .push(strb.txPush), .pushData(wrData),
    .pop(txLaunch), .popData(txHead), .empty(txEmpty), .full(txFull));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txState  <= PH_IDLE;
      txCnt    <= '0;
      txBit    <= '0;
      txShr    <= '0;
      txParBit <= 1'b0;
    end else if (tick) begin
      if (txLaunch) begin
        txShr    <= txHead;
        txParBit <= (^(txHead & dataMask)) ^ parOdd;
        txState  <= PH_START;
        txCnt    <= '0;
      end else begin
        unique case (txState)
          PH_IDLE: ;
          PH_START: begin
            if (txCnt == 6'd15) begin
              txState <= PH_DATA;
              txCnt   <= '0;
              txBit   <= '0;
            end else txCnt <= txCnt + 1'b1;
          end
          PH_DATA: begin
            if (txCnt == 6'd15) begin
              txCnt <= '0;
              txShr <= txShr >> 1;
              if (txBit == lastBit) txState <= parEn ? PH_PAR : PH_STOP;
              else txBit <= txBit + 1'b1;
            end else txCnt <= txCnt + 1'b1;
          end
          PH_PAR: begin
            if (txCnt == 6'd15) begin
              txState <= PH_STOP;
              txCnt   <= '0;
            end else txCnt <= txCnt + 1'b1;
          end
          PH_STOP: begin
            if (txCnt >= stopTicks - 6'd1) txState <= PH_IDLE;
            else txCnt <= txCnt + 1'b1;
          end
          default: txState <= PH_IDLE;
        endcase
      end
    end
  end

  always_comb begin
    unique case (txState)
      PH_START: txLine = 1'b0;
      PH_DATA:  txLine = txShr[0];
      PH_PAR:   txLine = txParBit;
      default:  txLine = 1'b1;
    endcase
  end

  // line routing for the test modes
  logic rxSrc;
  always_comb begin
    unique case (cfg.mode)
      MODE_ECHO:   begin txdOut = rxdIn; rxSrc = rxdIn;  end
      MODE_LOCAL:  begin txdOut = 1'b1;  rxSrc = txLine; end
      MODE_REMOTE: begin txdOut = rxdIn; rxSrc = 1'b1;   end
      default:     begin txdOut = txLine; rxSrc = rxdIn; end
    endcase
  end

  // receive engine
  logic [1:0] rxSync;
  logic       rxLine, rxArmed, rxPe, rxPush;
  phase_e     rxState;
  logic [3:0] rxCnt;
  logic [2:0] rxBit;
  logic [7:0] rxShr, rxChar;
  logic       rxEmpty, rxFull, ovr;
  logic [ENTRY_W-1:0] rxHead;

  assign rxLine = rxSync[1];
  assign rxChar = rxShr >> (2'd3 - cfg.charLen);
  assign rxPush = tick && (rxState == PH_STOP) && (rxCnt == 4'd15);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync  <= 2'b11;
      rxState <= PH_IDLE;
      rxArmed <= 1'b0;
      rxCnt   <= '0;
      rxBit   <= '0;
      rxShr   <= '0;
      rxPe    <= 1'b0;
    end else begin
      rxSync <= {rxSync[0], rxSrc};
      if (tick) begin
        unique case (rxState)
          PH_IDLE: begin
            if (rxLine) rxArmed <= 1'b1;
            else if (rxArmed) begin
              rxState <= PH_START;
              rxArmed <= 1'b0;
              rxCnt   <= '0;
              rxPe    <= 1'b0;
            end
          end
          PH_START: begin
            if (rxCnt == 4'd7) begin
              rxState <= rxLine ? PH_IDLE : PH_DATA;
              rxCnt   <= '0;
              rxBit   <= '0;
            end else rxCnt <= rxCnt + 1'b1;
          end
          PH_DATA: begin
            rxCnt <= rxCnt + 1'b1;
            if (rxCnt == 4'd15) begin
              rxShr <= {rxLine, rxShr[7:1]};
              if (rxBit == lastBit) rxState <= parEn ? PH_PAR : PH_STOP;
              else rxBit <= rxBit + 1'b1;
            end
          end
          PH_PAR: begin
            rxCnt <= rxCnt + 1'b1;
            if (rxCnt == 4'd15) begin
              rxPe    <= rxLine ^ (^rxChar) ^ parOdd;
              rxState <= PH_STOP;
            end
          end
          PH_STOP: begin
            rxCnt <= rxCnt + 1'b1;
            if (rxCnt == 4'd15) rxState <= PH_IDLE;
          end
          default: rxState <= PH_IDLE;
        endcase
      end
    end
  end

  uart_fifo #(.W(ENTRY_W), .DEPTH(RX_DEPTH)) rxQueue (
    .clk(clk), .rstN(rstN), .push(rxPush),
    .pushData({~rxLine, parEn & rxPe, rxChar}),
    .pop(strb.rxPop), .popData(rxHead), .empty(rxEmpty), .full(rxFull));

  always_ff @(posedge clk) begin
    if (!rstN) ovr <= 1'b0;
    else if (rxPush && rxFull && !strb.rxPop) ovr <= 1'b1;
    else if (strb.ovrClr) ovr <= 1'b0;
  end

  assign stat.rxAvail = !rxEmpty;
  assign stat.txSpace = !txFull;
  assign stat.headPe  = !rxEmpty && rxHead[8];
  assign stat.headFe  = !rxEmpty && rxHead[9];
  assign stat.overrun = ovr;
  assign stat.txIdle  = txEmpty && (txState == PH_IDLE);
  assign stat.rxData  = rxHead[7:0];

  assert_cts_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (txState == PH_IDLE && !ctsIn) |=> (txState == PH_IDLE));
  assert_overrun_set_R5: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull && !strb.rxPop) |=> ovr);
  assert_overrun_sticky_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ovr && !strb.ovrClr) |=> ovr);
endmodule

// File: rtl/uart_ctrl.sv
module uart_ctrl
  import uart_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       regSel,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [7:0]       wrData,
  input  logic             ctsIn,
  input  lineStat_t        stat,
  output strobe_t          strb,
  output frameCfg_t        cfg,
  output logic [DIV_W-1:0] divisor,
  output logic [7:0]       rdData,
  output logic             irq,
  output logic             rtsOut
);
  localparam int HI_W = DIV_W - 8;

  logic mskRx, mskTx, mskErr, errAny;

  assign strb.txPush = wrEn && (regSel == 3'd0);
  assign strb.rxPop  = rdEn && (regSel == 3'd0);
  assign strb.ovrClr = wrEn && (regSel == 3'd1) && wrData[4];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg.charLen   <= 2'd3;
      cfg.parity    <= 2'd0;
      cfg.stopExtra <= '0;
      cfg.mode      <= MODE_NORMAL;
      rtsOut        <= 1'b0;
      mskRx         <= 1'b0;
      mskTx         <= 1'b0;
      mskErr        <= 1'b0;
      divisor       <= DIV_W'(1);
    end else if (wrEn) begin
      unique case (regSel)
        3'd2: {cfg.parity, cfg.charLen} <= wrData[3:0];
        3'd3: cfg.stopExtra <= wrData[4:0];
        3'd4: begin
          cfg.mode <= lineMode_e'(wrData[1:0]);
          rtsOut   <= wrData[2];
          mskRx    <= wrData[3];
          mskTx    <= wrData[4];
          mskErr   <= wrData[5];
        end
        3'd5: divisor[7:0] <= wrData;
        3'd6: divisor[DIV_W-1:8] <= wrData[HI_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (regSel)
      3'd0: rdData = stat.rxData;
      3'd1: rdData = {1'b0, ctsIn, stat.txIdle, stat.overrun,
                      stat.headFe, stat.headPe, stat.txSpace, stat.rxAvail};
      3'd2: rdData = {4'b0, cfg.parity, cfg.charLen};
      3'd3: rdData = {3'b0, cfg.stopExtra};
      3'd4: rdData = {2'b0, mskErr, mskTx, mskRx, rtsOut, cfg.mode};
      3'd5: rdData = divisor[7:0];
      3'd6: rdData = 8'(divisor >> 8);
      default: rdData = 8'h00;
    endcase
  end

  assign errAny = stat.overrun || stat.headPe || stat.headFe;
  assign irq = (mskRx && stat.rxAvail) || (mskTx && stat.txSpace) || (mskErr && errAny);

  assert_rts_follow_R8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 3'd4) |=> (rtsOut == $past(wrData[2])));
  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rstN)
    (!mskRx && !mskTx && !mskErr) |-> !irq);
endmodule

// File: rtl/serial_uart.sv
module serial_uart
  import uart_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int RX_DEPTH = 4,
  parameter int TX_DEPTH = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irq,
  output logic       txd,
  input  logic       rxd,
  output logic       rtsOut,
  input  logic       ctsIn
);
  strobe_t          strb;
  frameCfg_t        cfg;
  lineStat_t        stat;
  logic [DIV_W-1:0] divisor;

  uart_ctrl #(.DIV_W(DIV_W)) ctrl (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .ctsIn(ctsIn), .stat(stat), .strb(strb), .cfg(cfg),
    .divisor(divisor), .rdData(rdData), .irq(irq), .rtsOut(rtsOut));

  uart_datapath #(.DIV_W(DIV_W), .RX_DEPTH(RX_DEPTH), .TX_DEPTH(TX_DEPTH)) dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cfg(cfg), .divisor(divisor),
    .wrData(wrData), .rxdIn(rxd), .ctsIn(ctsIn), .txdOut(txd), .stat(stat));
endmodule

// File: tb/tb_serial_uart.sv
module tb_serial_uart;
  localparam int CLK_PERIOD = 10;
  localparam int BIT_CLK    = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [2:0] regSel = '0;
  logic       wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic       irq, txd, rtsOut;
  logic       rxd = 1'b1, ctsIn = 1'b1;

  int vecs = 0, miss = 0;
  int lowCount = 0, echoMiss = 0;
  bit quietWatch = 0, echoWatch = 0, finished = 0;

  serial_uart dut (.clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .irq(irq), .txd(txd), .rxd(rxd),
    .rtsOut(rtsOut), .ctsIn(ctsIn));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    #1;
    if (quietWatch && txd == 1'b0) lowCount++;
    if (echoWatch && txd !== rxd) echoMiss++;
  end

  task automatic check(input string req, input int act, input int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); regSel = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); regSel = a; #1; d = rdData;
  endtask

  task automatic popRx(output logic [7:0] d);
    @(negedge clk); regSel = 3'd0; #1; d = rdData; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic waitStatus(input int bitIdx, output bit ok);
    logic [7:0] s;
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      peek(3'd1, s);
      if (s[bitIdx]) begin ok = 1; break; end
    end
  endtask

  task automatic waitFall(output bit ok);
    ok = 0;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk); #1;
      if (txd == 1'b0) begin ok = 1; break; end
    end
  endtask

  task automatic sendRx(input logic [7:0] d, input int nbits, input bit parEn,
                        input bit odd, input bit flipPar, input bit badStop);
    logic [7:0] m;
    m = 8'hFF >> (8 - nbits);
    @(negedge clk); rxd = 1'b0;
    repeat (BIT_CLK) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      rxd = d[i];
      repeat (BIT_CLK) @(negedge clk);
    end
    if (parEn) begin
      rxd = (^(d & m)) ^ odd ^ flipPar;
      repeat (BIT_CLK) @(negedge clk);
    end
    rxd = !badStop;
    repeat (BIT_CLK) @(negedge clk);
    rxd = 1'b1;
    repeat (BIT_CLK) @(negedge clk);
  endtask

  task automatic captureTx(input int bitClk, input int nbits, input bit parEn,
                           output logic [7:0] d, output logic p, output logic s);
    bit ok;
    d = '0; p = 1'b0;
    waitFall(ok);
    repeat (bitClk/2) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      repeat (bitClk) @(negedge clk); #1; d[i] = txd;
    end
    if (parEn) begin
      repeat (bitClk) @(negedge clk); #1; p = txd;
    end
    repeat (bitClk) @(negedge clk); #1; s = txd;
  endtask

  task automatic testReset();
    logic [7:0] s;
    peek(3'd1, s);
    check("R13 reset status", s, 8'h62);
    check("R1 reset txd idle high", txd, 1);
    check("R8 reset rts", rtsOut, 0);
    check("R12 reset irq", irq, 0);
  endtask

  task automatic testLocalFormats();
    logic [7:0] d, s, exp;
    bit ok;
    regWrite(3'd4, 8'h02);
    for (int len = 0; len < 4; len++) begin
      for (int par = 0; par < 3; par++) begin
        exp = (8'hA5 ^ 8'(len * 37 + par * 11)) & (8'hFF >> (3 - len));
        regWrite(3'd2, 8'((par << 2) | len));
        lowCount = 0; quietWatch = 1;
        regWrite(3'd0, 8'hA5 ^ 8'(len * 37 + par * 11));
        waitStatus(0, ok);
        quietWatch = 0;
        check("R10 local loop char received", ok, 1);
        peek(3'd1, s);
        check("R2 local loop parity flag clear", s[2], 0);
        check("R1 local loop framing flag clear", s[3], 0);
        popRx(d);
        check("R1 local loop data by length", d, exp);
        check("R10 txd held high in local loop", lowCount, 0);
      end
    end
    regWrite(3'd4, 8'h00);
    regWrite(3'd2, 8'h03);
  endtask

  task automatic testTxWaveform();
    logic [7:0] d;
    logic p, s;
    bit ok;
    int n;
    regWrite(3'd5, 8'd2);
    regWrite(3'd2, 8'h0A);
    regWrite(3'd0, 8'h35);
    waitFall(ok);
    n = 0;
    while (txd == 1'b0 && n < 1000) begin @(negedge clk); #1; n++; end
    check("R13 start bit length divisor 2", n, 48);
    repeat (24) @(negedge clk);
    d = '0;
    #1; d[0] = txd;
    for (int i = 1; i < 7; i++) begin repeat (48) @(negedge clk); #1; d[i] = txd; end
    repeat (48) @(negedge clk); #1; p = txd;
    repeat (48) @(negedge clk); #1; s = txd;
    check("R1 seven bit data on txd", d, 8'h35);
    check("R2 odd parity bit", p, !(^(8'h35 & 8'h7F)));
    check("R1 stop level high", s, 1);
    waitStatus(5, ok);
    regWrite(3'd5, 8'd1);
    regWrite(3'd2, 8'h07);
    regWrite(3'd0, 8'hC3);
    captureTx(BIT_CLK, 8, 1, d, p, s);
    check("R1 eight bit data on txd", d, 8'hC3);
    check("R2 even parity bit", p, ^8'hC3);
    waitStatus(5, ok);
    regWrite(3'd2, 8'h03);
  endtask

  task automatic testStopLength();
    int extras [3] = '{0, 8, 31};
    int expect_clk [3] = '{320, 336, 352};
    bit ok;
    int n;
    for (int k = 0; k < 3; k++) begin
      regWrite(3'd3, 8'(extras[k]));
      @(negedge clk); ctsIn = 1'b0;
      regWrite(3'd0, 8'hFF);
      regWrite(3'd0, 8'hFF);
      @(negedge clk); ctsIn = 1'b1;
      waitFall(ok);
      n = 0;
      while (txd == 1'b0 && n < 2000) begin @(negedge clk); #1; n++; end
      while (txd == 1'b1 && n < 2000) begin @(negedge clk); #1; n++; end
      check("R3 start to start spacing with stop extension", n, expect_clk[k]);
      waitStatus(5, ok);
    end
    regWrite(3'd3, 8'h00);
  endtask

  task automatic testCtsQueue();
    logic [7:0] d, s;
    logic p, st;
    @(negedge clk); ctsIn = 1'b0;
    regWrite(3'd0, 8'h11);
    regWrite(3'd0, 8'h22);
    peek(3'd1, s);
    check("R4 transmit queue full after two", s[1], 0);
    check("R13 status shows cts low", s[6], 0);
    regWrite(3'd0, 8'h33);
    lowCount = 0; quietWatch = 1;
    repeat (400) @(negedge clk);
    quietWatch = 0;
    check("R7 no start while cts low", lowCount, 0);
    @(negedge clk); ctsIn = 1'b1;
    captureTx(BIT_CLK, 8, 0, d, p, st);
    check("R7 first queued char after cts", d, 8'h11);
    captureTx(BIT_CLK, 8, 0, d, p, st);
    check("R4 second queued char", d, 8'h22);
    lowCount = 0; quietWatch = 1;
    repeat (600) @(negedge clk);
    quietWatch = 0;
    check("R4 write to full queue discarded", lowCount, 0);
    peek(3'd1, s);
    check("R13 transmit idle status", s[5], 1);
  endtask

  task automatic testRxErrors();
    logic [7:0] d, s;
    regWrite(3'd2, 8'h07);
    sendRx(8'h5A, 8, 1, 0, 0, 0);
    sendRx(8'h3C, 8, 1, 0, 1, 0);
    sendRx(8'h81, 8, 1, 0, 0, 1);
    peek(3'd1, s);
    check("R6 good char flags clear", s[3:2], 0);
    popRx(d);
    check("R6 good char data", d, 8'h5A);
    regWrite(3'd4, 8'h20);
    peek(3'd1, s);
    check("R6 parity error flag", s[3:2], 2'b01);
    check("R12 error interrupt on parity flag", irq, 1);
    popRx(d);
    check("R6 parity error char data", d, 8'h3C);
    peek(3'd1, s);
    check("R6 framing error flag", s[3:2], 2'b10);
    popRx(d);
    check("R6 framing error char data", d, 8'h81);
    check("R12 error interrupt clears", irq, 0);
    regWrite(3'd2, 8'h03);
    for (int i = 0; i < 5; i++) sendRx(8'h10 + 8'(i), 8, 0, 0, 0, 0);
    peek(3'd1, s);
    check("R5 overrun flag set", s[4], 1);
    check("R12 error interrupt on overrun", irq, 1);
    for (int i = 0; i < 4; i++) begin
      popRx(d);
      check("R4 receive queue holds four", d, 8'h10 + i);
    end
    peek(3'd1, s);
    check("R5 fifth char dropped", s[0], 0);
    regWrite(3'd1, 8'h10);
    peek(3'd1, s);
    check("R5 overrun cleared by write", s[4], 0);
    regWrite(3'd4, 8'h00);
  endtask

  task automatic testModes();
    logic [7:0] d, s;
    regWrite(3'd4, 8'h01);
    echoMiss = 0; echoWatch = 1;
    sendRx(8'h6E, 8, 0, 0, 0, 0);
    echoWatch = 0;
    check("R9 echo txd follows rxd", echoMiss, 0);
    peek(3'd1, s);
    check("R9 echo receiver stores char", s[0], 1);
    popRx(d);
    check("R9 echo received data", d, 8'h6E);
    regWrite(3'd4, 8'h03);
    echoMiss = 0; echoWatch = 1;
    sendRx(8'h93, 8, 0, 0, 0, 0);
    echoWatch = 0;
    check("R11 remote txd follows rxd", echoMiss, 0);
    peek(3'd1, s);
    check("R11 remote receiver stores nothing", s[0], 0);
    regWrite(3'd4, 8'h00);
  endtask

  task automatic testRtsIrq();
    logic [7:0] d;
    bit ok;
    regWrite(3'd4, 8'h04);
    check("R8 rts driven high", rtsOut, 1);
    regWrite(3'd4, 8'h00);
    check("R8 rts driven low", rtsOut, 0);
    regWrite(3'd4, 8'h10);
    check("R12 tx space interrupt", irq, 1);
    regWrite(3'd4, 8'h0A);
    check("R12 rx mask with empty queue", irq, 0);
    regWrite(3'd0, 8'h5C);
    waitStatus(0, ok);
    check("R12 rx ready interrupt", irq, 1);
    popRx(d);
    check("R10 loopback char for interrupt", d, 8'h5C);
    check("R12 interrupt drops after read", irq, 0);
    regWrite(3'd4, 8'h00);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      miss++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLocalFormats();
    testTxWaveform();
    testStopLength();
    testCtsQueue();
    testRxErrors();
    testModes();
    testRtsIrq();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end
endmodule